// File: doc/BRIEF.md
# Hot-Swap Bus Connection Controller

This block is the digital decision logic of a hot-swap buffer for a two-wire serial bus (SDA/SCL). It watches the backplane-side and card-side line levels and decides when the card bus may be joined to a live backplane bus. It drives a connect strobe for the analog switch, a precharge enable, a rise-time-accelerator enable and a ready flag. The buffering, the offset voltage, the precharge level and the current sources are outside this block.

After a power-good flag and an active-high enable are both seen, the controller arms two qualifiers on the backplane side: a STOP detector and an idle timer. It joins the buses only when both card-side lines are high and one of these qualifiers is met. It then holds the link through any later traffic until the enable drops or power-good is lost. Every input passes through a two-flop synchronizer first. A change at a port therefore reaches the outputs on the third rising clock edge.

Top module: `hot_swap_ctrl`

## Requirements
- R1: While `pwr_good` is low, all four outputs are low and any SDA/SCL activity on either side has no effect.
- R2: With `pwr_good` high and `enable` low, all four outputs are low, whatever the bus lines do.
- R3: With `pwr_good` and `enable` both high and no link yet, `prechg_en` is high and `link_on`, `accel_en` and `ready` are low.
- R4: The link is never made while `card_sda` or `card_scl` is low, even if a backplane qualifier has been met.
- R5: A STOP on the backplane side (`bp_sda` going from 0 to 1 while `bp_scl` stays 1) makes the link within a few cycles when the card side is high.
- R6: With both backplane lines high for `IDLE_CYC` consecutive synchronized cycles, the idle qualifier is met. Either backplane line seen low restarts the count from zero.
- R7: A rise of `bp_sda` while `bp_scl` is low is not a STOP and does not make the link.
- R8: Once linked, `link_on`, `accel_en` and `ready` are high and `prechg_en` is low. This holds whatever traffic follows on either side.
- R9: Dropping `enable` while linked releases the link and returns all outputs low. Raising it again goes back through the precharge state.
- R10: Dropping `pwr_good` in any state returns the block at once to lockout, with all outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply above lockout threshold (asynchronous) |
| enable | input | 1 | Active-high enable (asynchronous) |
| bp_sda | input | 1 | Backplane-side SDA level |
| bp_scl | input | 1 | Backplane-side SCL level |
| card_sda | input | 1 | Card-side SDA level |
| card_scl | input | 1 | Card-side SCL level |
| link_on | output | 1 | Connects the two sides of the switch |
| prechg_en | output | 1 | Enables line precharge |
| accel_en | output | 1 | Enables the rise-time accelerators |
| ready | output | 1 | High while the sides are connected |

## Verification
The assertions check the following on every cycle:
- The output code in lockout and while disabled.
- That a linked state persists while power and enable hold.
- That every rise of `link_on` was preceded by a high card side and a met qualifier.

Only the bench scenarios can show which orderings qualify:
- A STOP against a rise of SDA with SCL low.
- Restart of the idle count by a short SCL pulse.
- A qualifier met while the card is held low.
- Re-entry into precharge after enable or power-good is toggled.

// File: rtl/hsc_pkg.sv
// Package: shared state encoding for the hot-swap connection controller.
// Assumes: nothing beyond being compiled before its users.
package hsc_pkg;
    typedef enum logic [1:0] {
        ST_LOCK   = 2'd0,   // supply not good
        ST_OFF    = 2'd1,   // powered, disabled, isolated
        ST_ARMED  = 2'd2,   // precharging, waiting for a qualifier
        ST_LINKED = 2'd3    // sides joined
    } hsc_state_t;
endpackage

// File: rtl/hsc_sync.sv
// Module: bank of two-flop synchronizers, one per bit.
// Assumes: inputs are asynchronous level signals; reset value is zero.
module hsc_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // two register stages per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/hsc_qual.sv
// Module: backplane qualifiers - STOP detector and idle timer.
// Assumes: sda/scl are already synchronized. The timer only runs while
// armed is high. idle_met stays high while both lines remain high.
module hsc_qual #(
    parameter int IDLE_CYC = 20000,
    localparam int CW = $clog2(IDLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic sda,
    input  logic scl,
    output logic stop_seen,
    output logic idle_met
);
    logic          sda_prev, scl_prev;
    logic [CW-1:0] idle_cnt;

    // previous line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_prev <= 1'b0;
            scl_prev <= 1'b0;
        end else begin
            sda_prev <= sda;
            scl_prev <= scl;
        end
    end

    // STOP: data rises while clock is high in both samples
    always_comb stop_seen = armed && scl && scl_prev && sda && !sda_prev;

    // idle counter: restarts on any low line, saturates at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || !sda || !scl)
            idle_cnt <= '0;
        else if (idle_cnt != CW'(IDLE_CYC))
            idle_cnt <= idle_cnt + 1'b1;
    end

    always_comb idle_met = armed && (idle_cnt == CW'(IDLE_CYC));
endmodule

// File: rtl/hsc_fsm.sv
// Module: connection state machine with Moore-decoded outputs.
// Assumes: all inputs synchronized. Loss of power-good wins over
// everything else, and enable low wins over a link request.
module hsc_fsm
    import hsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pg,
    input  logic       en,
    input  logic       card_hi,
    input  logic       qual_ok,
    output hsc_state_t state,
    output logic       link_on,
    output logic       prechg_en,
    output logic       accel_en,
    output logic       ready
);
    hsc_state_t nxt;

    // next-state selection
    always_comb begin
        nxt = state;
        if (!pg)
            nxt = ST_LOCK;
        else if (!en)
            nxt = ST_OFF;
        else if (state == ST_LOCK || state == ST_OFF)
            nxt = ST_ARMED;
        else if (state == ST_ARMED && card_hi && qual_ok)
            nxt = ST_LINKED;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCK;
        else        state <= nxt;
    end

    // output decode
    always_comb begin
        link_on   = (state == ST_LINKED);
        ready     = (state == ST_LINKED);
        accel_en  = (state == ST_LINKED);
        prechg_en = (state == ST_ARMED);
    end
endmodule

// File: rtl/hot_swap_ctrl.sv
// Module: top of the hot-swap bus connection controller.
// Assumes: the six inputs are asynchronous levels. Outputs follow a port
// change on the third rising edge (two sync stages plus the state register).
module hot_swap_ctrl
    import hsc_pkg::*;
#(
    parameter int IDLE_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic enable,
    input  logic bp_sda,
    input  logic bp_scl,
    input  logic card_sda,
    input  logic card_scl,
    output logic link_on,
    output logic prechg_en,
    output logic accel_en,
    output logic ready
);
    logic [5:0] raw_in, syn_in;
    logic       pg_s, en_s, bp_sda_s, bp_scl_s, cd_sda_s, cd_scl_s;
    logic       stop_seen, idle_met, armed;
    hsc_state_t state;

    always_comb raw_in = {pwr_good, enable, bp_sda, bp_scl, card_sda, card_scl};

    hsc_sync #(.W(6)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(syn_in)
    );

    // unpack the synchronized bits
    always_comb {pg_s, en_s, bp_sda_s, bp_scl_s, cd_sda_s, cd_scl_s} = syn_in;

    always_comb armed = (state == ST_ARMED);

    hsc_qual #(.IDLE_CYC(IDLE_CYC)) u_qual (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .sda(bp_sda_s), .scl(bp_scl_s),
        .stop_seen(stop_seen), .idle_met(idle_met)
    );

    hsc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pg(pg_s), .en(en_s),
        .card_hi(cd_sda_s && cd_scl_s),
        .qual_ok(stop_seen || idle_met),
        .state(state),
        .link_on(link_on), .prechg_en(prechg_en),
        .accel_en(accel_en), .ready(ready)
    );
endmodule

// File: rtl/hsc_chk.sv
// Module: property checker bound to hot_swap_ctrl.
// Assumes: it observes the synchronized inputs, the qualifier outputs
// and the top-level outputs.
module hsc_chk (
    input logic clk,
    input logic rst_n,
    input logic pg_s,
    input logic en_s,
    input logic cd_sda_s,
    input logic cd_scl_s,
    input logic stop_seen,
    input logic idle_met,
    input logic link_on,
    input logic prechg_en,
    input logic accel_en,
    input logic ready
);
    // R10
    lockout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_s |=> !link_on && !prechg_en && !accel_en && !ready);
    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_s && !en_s |=> !link_on && !prechg_en && !accel_en && !ready);
    // R8
    link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_on && pg_s && en_s |=> link_on);
    // R8
    linked_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_on |-> ready && accel_en && !prechg_en);
    // R4
    card_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_on) |-> $past(cd_sda_s && cd_scl_s));
    // R5 R6
    qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_on) |-> $past(stop_seen || idle_met));
endmodule

bind hot_swap_ctrl hsc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pg_s(pg_s), .en_s(en_s),
    .cd_sda_s(cd_sda_s), .cd_scl_s(cd_scl_s),
    .stop_seen(stop_seen), .idle_met(idle_met),
    .link_on(link_on), .prechg_en(prechg_en),
    .accel_en(accel_en), .ready(ready)
);

// File: tb/sim_hot_swap_ctrl.sv
// Scoreboard bench: the driver pushes expected output codes into a queue,
// and a monitor pops and compares them on the falling edge.
module sim_hot_swap_ctrl;
    localparam int IDLE = 64;
    // expected code order: {link_on, prechg_en, accel_en, ready}
    localparam logic [3:0] C_OFF  = 4'b0000;
    localparam logic [3:0] C_ARM  = 4'b0100;
    localparam logic [3:0] C_LINK = 4'b1011;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pwr_good = 1'b0, enable = 1'b0;
    logic bp_sda = 1'b1, bp_scl = 1'b1, card_sda = 1'b1, card_scl = 1'b1;
    logic link_on, prechg_en, accel_en, ready;

    int total = 0, bad = 0, cyc = 0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #2.5 clk = ~clk;

    hot_swap_ctrl #(.IDLE_CYC(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .enable(enable),
        .bp_sda(bp_sda), .bp_scl(bp_scl), .card_sda(card_sda),
        .card_scl(card_scl), .link_on(link_on), .prechg_en(prechg_en),
        .accel_en(accel_en), .ready(ready)
    );

    // monitor: compare queued expectations with the outputs
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            logic [3:0] act;
            it  = sbq.pop_front();
            act = {link_on, prechg_en, accel_en, ready};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: queue an expectation, let the monitor consume it
    task automatic expect_code(input logic [3:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sbq.push_back(it);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        wait_cyc(4);
        expect_code(C_OFF, "R1 reset state");
        rst_n = 1'b1;
        // R1: bus activity in lockout, enable high
        enable = 1'b1;
        wait_cyc(3);
        bp_sda = 1'b0; wait_cyc(2); bp_sda = 1'b1;
        card_sda = 1'b0; wait_cyc(2); card_sda = 1'b1;
        wait_cyc(IDLE + 10);
        expect_code(C_OFF, "R1 lockout ignores bus");
        // R2: powered but disabled
        enable = 1'b0; pwr_good = 1'b1;
        wait_cyc(IDLE + 10);
        expect_code(C_OFF, "R2 disabled idle bus");
        // R3: arm with backplane SDA held low
        bp_sda = 1'b0; enable = 1'b1;
        wait_cyc(6);
        expect_code(C_ARM, "R3 precharge state");
        wait_cyc(IDLE + 10);
        expect_code(C_ARM, "R6 no idle while sda low");
        // R4: STOP while card low
        card_sda = 1'b0;
        wait_cyc(4);
        bp_sda = 1'b1;
        wait_cyc(6);
        expect_code(C_ARM, "R4 stop with card low");
        wait_cyc(IDLE + 10);
        expect_code(C_ARM, "R4 idle with card low");
        card_sda = 1'b1;
        wait_cyc(6);
        expect_code(C_LINK, "R6 idle then card high");
        // R8: traffic after link
        bp_scl = 1'b0; card_sda = 1'b0; wait_cyc(3);
        bp_sda = 1'b0; card_scl = 1'b0; wait_cyc(3);
        bp_scl = 1'b1; card_sda = 1'b1; card_scl = 1'b1; wait_cyc(3);
        bp_sda = 1'b1;
        wait_cyc(6);
        expect_code(C_LINK, "R8 link held through traffic");
        // R9: release on enable drop
        enable = 1'b0;
        wait_cyc(6);
        expect_code(C_OFF, "R9 enable drop releases");
        // R5: STOP path, well before the idle time
        bp_sda = 1'b0; enable = 1'b1;
        wait_cyc(8);
        expect_code(C_ARM, "R9 re-enable precharges");
        bp_sda = 1'b1;
        wait_cyc(6);
        expect_code(C_LINK, "R5 stop makes link");
        // R7: SDA rising with SCL low is not a STOP
        enable = 1'b0;
        wait_cyc(6);
        bp_sda = 1'b0; bp_scl = 1'b0; enable = 1'b1;
        wait_cyc(8);
        bp_sda = 1'b1;
        wait_cyc(6);
        expect_code(C_ARM, "R7 no stop with scl low");
        // R6: idle count restart on a short SCL low
        bp_scl = 1'b1;
        wait_cyc(IDLE / 2);
        bp_scl = 1'b0; wait_cyc(2); bp_scl = 1'b1;
        wait_cyc(IDLE / 2 + 8);
        expect_code(C_ARM, "R6 count restarted");
        wait_cyc(IDLE / 2 + 4);
        expect_code(C_LINK, "R6 idle qualifier met");
        // R10: power loss while linked
        pwr_good = 1'b0;
        wait_cyc(6);
        expect_code(C_OFF, "R10 power loss locks out");
        pwr_good = 1'b1;
        wait_cyc(6);
        expect_code(C_ARM, "R10 power back re-arms");
        wait_cyc(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule